// File: doc/BRIEF.md
# PHY Event Interrupt Status Unit

This unit gathers link-related events raised by the core logic of a network PHY and turns them into a single level-sensitive interrupt request. Every event arrives as a one-cycle strobe on its own bit of an event vector. The unit records each strobe in a sticky status register, so nothing is lost between software visits.

Software reaches two 16-bit registers through a simple management-side access port. The enable mask sits at one address and the pending-event register sits at the next address up. Reading the pending-event register returns every outstanding event and clears them all in the same access, so one read acknowledges everything. The interrupt request is high whenever some pending event is also enabled. Events are recorded whatever the mask holds, so setting a mask bit later raises the request at once if that event is already pending. A common setup enables only link-state change and auto-downspeed.

Top module: `phy_evt_irq_unit`

## Requirements
- R1: A synchronous active-high reset clears the mask and the pending-event register to zero, and `irq_req` is low after the reset edge.
- R2: A strobe on an implemented bit of `evt_strobe` sets the matching pending bit at the next clock edge whatever the mask holds, and the bit stays set until a pending-event read clears it.
- R3: A read (`mgmt_rd` high) at address `MASK_ADDR+1` (default 0x1A) returns the pending bits combinationally in that cycle and clears all of them at the end of that cycle.
- R4: A strobe that arrives in the same cycle as a pending-event read is still pending after that read.
- R5: Reserved positions 4, 6, 7, 8 and 9 never set and always read as zero, even when strobed.
- R6: `irq_req` is high exactly when at least one bit is set in both the pending-event register and the mask; it is a level, active high.
- R7: A write (`mgmt_wr` high) at address `MASK_ADDR` (default 0x19) loads `mgmt_wdata` into the mask at the clock edge, and a read there returns the mask; a write to the pending-event address has no effect, and reads of any other address return zero and clear nothing.
- R8: A mask of zero holds `irq_req` low for any pending events; writing a mask bit for an event that is already pending raises `irq_req` after that write's clock edge.
- R9: Event bit positions are: 0 link state change, 1 link speed change, 2 duplex change, 3 MDI/MDI-X crossover change, 5 auto-downspeed, 10 auto-negotiation complete, 11 auto-negotiation error, 12 to 14 further sources, 15 wake-on-LAN; mask bit n enables pending bit n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_strobe | input | 16 | One-cycle event strobes, one bit per event position |
| mgmt_addr | input | 5 | Register address for the management access |
| mgmt_wr | input | 1 | Write request for the current cycle |
| mgmt_rd | input | 1 | Read request for the current cycle |
| mgmt_wdata | input | 16 | Write data |
| mgmt_rdata | output | 16 | Read data, valid in the cycle of `mgmt_rd` |
| irq_req | output | 1 | Interrupt request, level, active high |

## Verification
The assertions take for granted that `mgmt_wr` and `mgmt_rd` are never high in the same cycle, since there is only one address bus, and that the inputs are steady around the rising edge. The bench drives every input on the falling edge and issues at most one access per cycle, so both hold throughout. Strobes on reserved positions are driven on purpose, because the assertions are meant to show that such strobes leave no trace.

// File: rtl/phy_evt_pkg.sv
package phy_evt_pkg;

  localparam int unsigned EVT_W  = 16;
  localparam int unsigned ADDR_W = 5;

  // event bit positions
  localparam int unsigned EV_LINK_STATE = 0;
  localparam int unsigned EV_LINK_SPEED = 1;
  localparam int unsigned EV_DUPLEX     = 2;
  localparam int unsigned EV_MDIX       = 3;
  localparam int unsigned EV_DOWNSPEED  = 5;
  localparam int unsigned EV_ANEG_DONE  = 10;
  localparam int unsigned EV_ANEG_ERR   = 11;
  localparam int unsigned EV_WAKE       = 15;

  // map of implemented positions: 0-3, 5, 10-15
  localparam logic [EVT_W-1:0] IMPL_MAP = 16'hFC2F;

  typedef enum logic [1:0] {
    ACC_NONE   = 2'd0,
    ACC_MASK   = 2'd1,
    ACC_STATUS = 2'd2,
    ACC_OTHER  = 2'd3
  } acc_sel_e;

  function automatic acc_sel_e decode_addr(input logic [ADDR_W-1:0] addr,
                                           input logic [ADDR_W-1:0] mask_addr,
                                           input logic              active);
    if (!active)                  return ACC_NONE;
    if (addr == mask_addr)        return ACC_MASK;
    if (addr == mask_addr + 1'b1) return ACC_STATUS;
    return ACC_OTHER;
  endfunction

  function automatic logic [EVT_W-1:0] next_pending(input logic [EVT_W-1:0] cur,
                                                    input logic [EVT_W-1:0] strobes,
                                                    input logic             clr,
                                                    input logic [EVT_W-1:0] impl);
    logic [EVT_W-1:0] kept;
    kept = clr ? '0 : cur;
    return (kept | strobes) & impl;
  endfunction

endpackage

// File: rtl/evt_status_reg.sv
module evt_status_reg
  import phy_evt_pkg::*;
#(
  parameter int unsigned          W    = EVT_W,
  parameter logic [EVT_W-1:0]     IMPL = IMPL_MAP
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_i,
  input  logic         clr_i,
  output logic [W-1:0] status_o
);

  logic [W-1:0] nxt;
  assign nxt = next_pending(status_o, evt_i, clr_i, IMPL[W-1:0]);

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (IMPL[b]) begin : g_impl
      always_ff @(posedge clk) begin
        if (rst) status_o[b] <= 1'b0;
        else     status_o[b] <= nxt[b];
      end
    end else begin : g_rsvd
      assign status_o[b] = 1'b0;
    end
  end

  logic [W-1:0] evt_impl;
  assign evt_impl = evt_i & IMPL[W-1:0];

  AST_EVT_LATCH: assert property (@(posedge clk) disable iff (rst)
    (evt_impl != '0) |=> ((status_o & $past(evt_impl)) == $past(evt_impl))) // R2
    else $error("event strobe not latched");

  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> ((status_o & $past(status_o)) == $past(status_o))) // R2
    else $error("pending bit dropped without read");

  AST_CLR_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (clr_i && evt_i == '0) |=> (status_o == '0)) // R3
    else $error("pending bits survive a read");

  AST_KEEP_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (clr_i && evt_impl != '0) |=> (status_o == $past(evt_impl))) // R4
    else $error("same-cycle strobe lost to clear");

  AST_RSVD_ZERO: assert property (@(posedge clk)
    (status_o & ~IMPL[W-1:0]) == '0) // R5
    else $error("reserved pending bit set");

endmodule

// File: rtl/mask_reg.sv
module mask_reg
  import phy_evt_pkg::*;
#(
  parameter int unsigned W = EVT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);

  always_ff @(posedge clk) begin
    if (rst)       mask_o <= '0;
    else if (we_i) mask_o <= wdata_i;
  end

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> $stable(mask_o)) // R7
    else $error("mask changed without write");

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
    we_i |=> (mask_o == $past(wdata_i))) // R7
    else $error("mask write not taken");

endmodule

// File: rtl/reg_decode.sv
module reg_decode
  import phy_evt_pkg::*;
#(
  parameter int unsigned          W         = EVT_W,
  parameter int unsigned          AW        = ADDR_W,
  parameter logic [AW-1:0]        MASK_ADDR = 5'h19
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [W-1:0]  mask_i,
  input  logic [W-1:0]  status_i,
  output logic          mask_we_o,
  output logic          status_clr_o,
  output logic [W-1:0]  rdata_o
);

  acc_sel_e wr_sel, rd_sel;
  assign wr_sel = decode_addr(addr_i, MASK_ADDR, wr_i);
  assign rd_sel = decode_addr(addr_i, MASK_ADDR, rd_i);

  assign mask_we_o    = (wr_sel == ACC_MASK);
  assign status_clr_o = (rd_sel == ACC_STATUS);

  always_comb begin
    unique case (rd_sel)
      ACC_MASK:   rdata_o = mask_i;
      ACC_STATUS: rdata_o = status_i;
      default:    rdata_o = '0;
    endcase
  end

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (rst)
    !(wr_i && rd_i)) // R7
    else $error("write and read in one cycle");

  AST_CLR_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
    status_clr_o |-> (rd_i && !wr_i)) // R3
    else $error("clear without status read");

endmodule

// File: rtl/irq_combine.sv
module irq_combine
  import phy_evt_pkg::*;
#(
  parameter int unsigned W = EVT_W
) (
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_o
);

  logic [W-1:0] hit;
  for (genvar b = 0; b < W; b++) begin : g_hit
    assign hit[b] = status_i[b] & mask_i[b];
  end

  assign irq_o = |hit;

endmodule

// File: rtl/phy_evt_irq_unit.sv
module phy_evt_irq_unit
  import phy_evt_pkg::*;
#(
  parameter int unsigned          W         = EVT_W,
  parameter int unsigned          AW        = ADDR_W,
  parameter logic [AW-1:0]        MASK_ADDR = 5'h19
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  evt_strobe,
  input  logic [AW-1:0] mgmt_addr,
  input  logic          mgmt_wr,
  input  logic          mgmt_rd,
  input  logic [W-1:0]  mgmt_wdata,
  output logic [W-1:0]  mgmt_rdata,
  output logic          irq_req
);

  logic [W-1:0] status_q;
  logic [W-1:0] mask_q;
  logic         mask_we;
  logic         status_clr;

  reg_decode #(.W(W), .AW(AW), .MASK_ADDR(MASK_ADDR)) u_dec (
    .clk          (clk),
    .rst          (rst),
    .addr_i       (mgmt_addr),
    .wr_i         (mgmt_wr),
    .rd_i         (mgmt_rd),
    .mask_i       (mask_q),
    .status_i     (status_q),
    .mask_we_o    (mask_we),
    .status_clr_o (status_clr),
    .rdata_o      (mgmt_rdata)
  );

  mask_reg #(.W(W)) u_mask (
    .clk     (clk),
    .rst     (rst),
    .we_i    (mask_we),
    .wdata_i (mgmt_wdata),
    .mask_o  (mask_q)
  );

  evt_status_reg #(.W(W), .IMPL(IMPL_MAP)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .evt_i    (evt_strobe),
    .clr_i    (status_clr),
    .status_o (status_q)
  );

  irq_combine #(.W(W)) u_irq (
    .status_i (status_q),
    .mask_i   (mask_q),
    .irq_o    (irq_req)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (status_q == '0 && mask_q == '0 && !irq_req)) // R1
    else $error("reset did not clear state");

  AST_MASK_ZERO_QUIET: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |-> !irq_req) // R8
    else $error("irq with empty mask");

  AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (status_q != '0)) // R6
    else $error("irq without pending event");

endmodule

// File: tb/phy_evt_irq_unit_tb_top.sv
`timescale 1ns/1ps
module phy_evt_irq_unit_tb_top;

  localparam logic [4:0] A_MASK = 5'h19;
  localparam logic [4:0] A_STAT = 5'h1A;
  localparam int NV = 15;
  // vector: op[50:49] (0 idle,1 mask write,2 status read), data[48:33], evt[32:17], exp_rd[16:1], exp_irq[0]
  localparam logic [50:0] VEC [NV] = '{
    {2'd1, 16'h0021, 16'h0000, 16'h0000, 1'b0},
    {2'd0, 16'h0000, 16'h0001, 16'h0000, 1'b1},
    {2'd2, 16'h0000, 16'h0000, 16'h0001, 1'b0},
    {2'd0, 16'h0000, 16'h0400, 16'h0000, 1'b0},
    {2'd0, 16'h0000, 16'h03D0, 16'h0000, 1'b0},
    {2'd2, 16'h0000, 16'h0000, 16'h0400, 1'b0},
    {2'd0, 16'h0000, 16'h0020, 16'h0000, 1'b1},
    {2'd2, 16'h0000, 16'h0001, 16'h0020, 1'b1},
    {2'd2, 16'h0000, 16'h0000, 16'h0001, 1'b0},
    {2'd0, 16'h0000, 16'h8000, 16'h0000, 1'b0},
    {2'd1, 16'h8000, 16'h0000, 16'h0000, 1'b1},
    {2'd1, 16'h0000, 16'h0000, 16'h0000, 1'b0},
    {2'd2, 16'h0000, 16'h0000, 16'h8000, 1'b0},
    {2'd0, 16'h0000, 16'hFFFF, 16'h0000, 1'b0},
    {2'd2, 16'h0000, 16'h0000, 16'hFC2F, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] evt_strobe = '0;
  logic [4:0]  mgmt_addr = '0;
  logic        mgmt_wr = 1'b0;
  logic        mgmt_rd = 1'b0;
  logic [15:0] mgmt_wdata = '0;
  logic [15:0] mgmt_rdata;
  logic        irq_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  phy_evt_irq_unit dut_i (
    .clk(clk), .rst(rst), .evt_strobe(evt_strobe), .mgmt_addr(mgmt_addr),
    .mgmt_wr(mgmt_wr), .mgmt_rd(mgmt_rd), .mgmt_wdata(mgmt_wdata),
    .mgmt_rdata(mgmt_rdata), .irq_req(irq_req)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle at the falling edge; returns read data sampled before the rising edge
  task automatic cycle(input logic [4:0] a, input logic wr, input logic rd,
                       input logic [15:0] wd, input logic [15:0] ev,
                       output logic [15:0] rd_val);
    @(negedge clk);
    mgmt_addr = a; mgmt_wr = wr; mgmt_rd = rd; mgmt_wdata = wd; evt_strobe = ev;
    #1 rd_val = mgmt_rdata;
    @(posedge clk);
    #1;
    mgmt_wr = 1'b0; mgmt_rd = 1'b0; evt_strobe = '0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1 reset state
    chk("R1 irq after reset", {15'd0, irq_req}, 16'h0000);
    cycle(A_STAT, 1'b0, 1'b1, '0, '0, r);
    chk("R1 status after reset", r, 16'h0000);
    cycle(A_MASK, 1'b0, 1'b1, '0, '0, r);
    chk("R1 mask after reset", r, 16'h0000);

    // table walk: R2 R3 R4 R5 R6 R8 R9
    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [15:0] d, ev, erd;
      op = VEC[i][50:49]; d = VEC[i][48:33]; ev = VEC[i][32:17]; erd = VEC[i][16:1];
      cycle(op == 2'd1 ? A_MASK : A_STAT, op == 2'd1, op == 2'd2, d, ev, r);
      if (op == 2'd2) chk($sformatf("R3/R4/R5 read vec %0d", i), r, erd);
      chk($sformatf("R6/R8 irq vec %0d", i), {15'd0, irq_req}, {15'd0, VEC[i][0]});
    end

    // R7 mask readback, status write ignored, other address reads zero and clears nothing
    cycle(A_MASK, 1'b1, 1'b0, 16'h1234, '0, r);
    cycle(A_MASK, 1'b0, 1'b1, '0, '0, r);
    chk("R7 mask readback", r, 16'h1234);
    cycle(A_MASK, 1'b1, 1'b0, 16'h0000, 16'h0002, r);
    cycle(A_STAT, 1'b1, 1'b0, 16'h0000, '0, r);
    cycle(5'h03, 1'b0, 1'b1, '0, '0, r);
    chk("R7 other address reads zero", r, 16'h0000);
    cycle(5'h03, 1'b1, 1'b0, 16'hFFFF, '0, r);
    chk("R7 other address write leaves irq low", {15'd0, irq_req}, 16'h0000);
    cycle(A_STAT, 1'b0, 1'b1, '0, '0, r);
    chk("R7 status write ignored, R2 link speed bit1", r, 16'h0002);

    // R9 each named position with its own mask bit
    for (int b = 0; b < 16; b++) begin
      logic [15:0] one;
      one = 16'h1 << b;
      cycle(A_MASK, 1'b1, 1'b0, one, one, r);
      chk($sformatf("R9 irq for bit %0d", b), {15'd0, irq_req}, {15'd0, (16'hFC2F >> b) & 16'h1} & 16'h1);
      cycle(A_STAT, 1'b0, 1'b1, '0, '0, r);
      chk($sformatf("R9 readback bit %0d", b), r, one & 16'hFC2F);
    end

    // R1 reset in mid-run
    cycle(A_MASK, 1'b1, 1'b0, 16'hFFFF, 16'h0C00, r);
    chk("R6 irq before reset", {15'd0, irq_req}, 16'h0001);
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #1;
    chk("R1 irq cleared by reset", {15'd0, irq_req}, 16'h0000);
    @(negedge clk) rst = 1'b0;
    cycle(A_STAT, 1'b0, 1'b1, '0, '0, r);
    chk("R1 status cleared by reset", r, 16'h0000);
    cycle(A_MASK, 1'b0, 1'b1, '0, '0, r);
    chk("R1 mask cleared by reset", r, 16'h0000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule